// File: doc/BRIEF.md
# Cache region maintenance controller

This block is the maintenance engine that sits beside a system-level cache. Software programs it through a small auxiliary register bus: a control word chooses the kind of region operation and the invalidate mode, an end address is written next, and the write of the start address launches the work. The engine walks every cache line from the line holding the start address to the line holding the end address and hands one line command at a time to the cache over a valid/ready port.

Two further command registers start whole-cache work: one flushes every line, the other invalidates every line, or flushes and then invalidates each line when the invalidate-mode bit is set. For whole-cache work the engine walks line indices 0 to `CACHE_LINES-1` and presents each index in the line-address field of the command. A busy flag in the control word tells software when the last line command has been accepted. Optional upper start and end registers widen the physical address past the bus data width.

Top module: `cache_region_maint`

## Requirements
- R1: After reset the control word reads 0, `cmd_valid` is 0 and `cache_off` is 0.
- R2: The control word at 0x903 stores bit 0 (cache disable, driven on `cache_off`), bit 6 (invalidate mode) and bits 11:9 (region code); bit 8 reads the busy flag and every other bit reads 0.
- R3: A write to the start-low register (0x914) while idle launches a region walk that issues one command per line, from the line holding `{start_hi, start_lo}` up to the line holding `{end_hi, end_lo}`, in ascending order, with `cmd_addr` line aligned (low `log2(LINE_BYTES)` bits zero).
- R4: Command codes on `cmd_op` are 01 flush, 10 invalidate, 11 flush-then-invalidate. A region code with bit 9 clear gives flush; with bit 9 set it gives invalidate when the mode bit is 0 and flush-then-invalidate when it is 1.
- R5: Address bits below the line size are ignored in both the start and end registers.
- R6: When the end line lies below the start line, no command is issued and busy is 1 for exactly one cycle.
- R7: Writing a value with bit 0 set to 0x904 issues flush commands for line indices 0 to `CACHE_LINES-1`; doing the same at 0x905 issues invalidate commands, or flush-then-invalidate when the mode bit is 1. `cmd_addr` carries index times `LINE_BYTES`.
- R8: Busy reads 1 from the first read after a launching write and drops to 0 in the cycle after the last command is accepted.
- R9: A presented command holds its address and code until `cmd_ready` is seen.
- R10: While busy, writes to the start registers and to 0x904/0x905 are ignored (start registers keep their values, no new walk begins); control writes are stored but do not change the walk in progress.
- R11: The start-high (0x915) and end-high (0x917) registers store `HI_W` bits that form the address bits above `DATA_W`; with `HAS_HI` = 0 they read as 0. End registers (0x916, 0x917) read back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | AUX_AW | Register address for reads and writes |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| cache_off | output | 1 | Cache disable bit from the control word |
| cmd_valid | output | 1 | A line command is presented |
| cmd_ready | input | 1 | The cache accepts the presented command |
| cmd_addr | output | DATA_W+HI_W | Line-aligned address or whole-cache line index times line size |
| cmd_op | output | 2 | 01 flush, 10 invalidate, 11 flush-then-invalidate |

## Verification
The bench targets a region whose end line sits below its start line, which a careless design would turn into a wrap-around walk of almost the whole address space; start and end addresses with junk in the low bits, which a design that compared raw addresses would miscount by one line; and start addresses whose line walk crosses into the upper address register, where a dropped upper bit would send commands to the wrong place. It also fires a second start write and a whole-cache command in the middle of a stalled walk and rewrites the control word then, so a design that relaunched or re-read the mode would change addresses or codes mid-walk, and it stalls `cmd_ready` at random, so a design that advanced without a handshake would skip lines.

// File: rtl/cache_region_maint.sv
module cache_region_maint #(
  parameter int AUX_AW      = 12,
  parameter int DATA_W      = 32,
  parameter int HI_W        = 8,
  parameter bit HAS_HI      = 1'b1,
  parameter int LINE_BYTES  = 64,
  parameter int CACHE_LINES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wen,
  input  logic [AUX_AW-1:0]      reg_addr,
  input  logic [DATA_W-1:0]      reg_wdata,
  output logic [DATA_W-1:0]      reg_rdata,
  output logic                   cache_off,
  output logic                   cmd_valid,
  input  logic                   cmd_ready,
  output logic [DATA_W+HI_W-1:0] cmd_addr,
  output logic [1:0]             cmd_op
);
  localparam int OFF  = $clog2(LINE_BYTES);
  localparam int PA_W = DATA_W + HI_W;
  localparam int LW   = PA_W - OFF;
  localparam logic [AUX_AW-1:0] A_CTRL = AUX_AW'(12'h903);
  localparam logic [AUX_AW-1:0] A_FALL = AUX_AW'(12'h904);
  localparam logic [AUX_AW-1:0] A_IALL = AUX_AW'(12'h905);
  localparam logic [AUX_AW-1:0] A_SLO  = AUX_AW'(12'h914);
  localparam logic [AUX_AW-1:0] A_SHI  = AUX_AW'(12'h915);
  localparam logic [AUX_AW-1:0] A_ELO  = AUX_AW'(12'h916);
  localparam logic [AUX_AW-1:0] A_EHI  = AUX_AW'(12'h917);

  logic              dis_q, im_q, busy_q, vld_q;
  logic [2:0]        rop_q;
  logic [DATA_W-1:0] st_lo, en_lo;
  logic [HI_W-1:0]   st_hi, en_hi;
  logic [LW-1:0]     cur_q, last_q;
  logic [1:0]        op_q;

  wire wr_ctrl = reg_wen && reg_addr == A_CTRL;
  wire wr_slo  = reg_wen && reg_addr == A_SLO;
  wire go_rgn  = wr_slo && !busy_q;
  wire go_fall = reg_wen && reg_addr == A_FALL && reg_wdata[0] && !busy_q;
  wire go_iall = reg_wen && reg_addr == A_IALL && reg_wdata[0] && !busy_q;

  wire [PA_W-1:0] s_pa = {st_hi, reg_wdata};
  wire [PA_W-1:0] e_pa = {en_hi, en_lo};
  wire [LW-1:0]   s_ln = s_pa[PA_W-1:OFF];
  wire [LW-1:0]   e_ln = e_pa[PA_W-1:OFF];
  wire [1:0]      inv_op = im_q ? 2'b11 : 2'b10;
  wire [1:0]      rgn_op = rop_q[0] ? inv_op : 2'b01;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dis_q <= 1'b0; im_q <= 1'b0; rop_q <= '0;
      st_lo <= '0; st_hi <= '0; en_lo <= '0; en_hi <= '0;
    end else begin
      if (wr_ctrl) begin
        dis_q <= reg_wdata[0];
        im_q  <= reg_wdata[6];
        rop_q <= reg_wdata[11:9];
      end
      if (go_rgn) st_lo <= reg_wdata;
      if (HAS_HI && reg_wen && reg_addr == A_SHI && !busy_q) st_hi <= reg_wdata[HI_W-1:0];
      if (reg_wen && reg_addr == A_ELO) en_lo <= reg_wdata;
      if (HAS_HI && reg_wen && reg_addr == A_EHI) en_hi <= reg_wdata[HI_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0; vld_q <= 1'b0; cur_q <= '0; last_q <= '0; op_q <= '0;
    end else if (go_rgn) begin
      busy_q <= 1'b1;
      vld_q  <= e_ln >= s_ln;
      cur_q  <= s_ln;
      last_q <= e_ln;
      op_q   <= rgn_op;
    end else if (go_fall || go_iall) begin
      busy_q <= 1'b1;
      vld_q  <= 1'b1;
      cur_q  <= '0;
      last_q <= LW'(CACHE_LINES - 1);
      op_q   <= go_fall ? 2'b01 : inv_op;
    end else if (busy_q) begin
      if (!vld_q) busy_q <= 1'b0;
      else if (cmd_ready) begin
        if (cur_q == last_q) begin
          busy_q <= 1'b0;
          vld_q  <= 1'b0;
        end else cur_q <= cur_q + 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[0]    = dis_q;
        reg_rdata[6]    = im_q;
        reg_rdata[8]    = busy_q;
        reg_rdata[11:9] = rop_q;
      end
      A_SLO: reg_rdata = st_lo;
      A_SHI: reg_rdata = DATA_W'(st_hi);
      A_ELO: reg_rdata = en_lo;
      A_EHI: reg_rdata = DATA_W'(en_hi);
      default: reg_rdata = '0;
    endcase
  end

  assign cache_off = dis_q;
  assign cmd_valid = vld_q;
  assign cmd_addr  = {cur_q, {OFF{1'b0}}};
  assign cmd_op    = op_q;

  a_r9_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_op));
  a_r8_valid_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy_q);
  a_r3_next_line: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_valid || cmd_addr == $past(cmd_addr) + PA_W'(LINE_BYTES));
  a_r8_launch_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_slo && !busy_q |=> busy_q);
  a_r10_start_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_slo && busy_q |=> $stable(st_lo));
endmodule

// File: tb/sim_cache_region_maint.sv
module sim_cache_region_maint;
  localparam int LB = 64;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wen = 1'b0, cmd_ready = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic cache_off, cmd_valid;
  logic [39:0] cmd_addr;
  logic [1:0] cmd_op;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  cache_region_maint u0 (.clk, .rst_n, .reg_wen, .reg_addr, .reg_wdata, .reg_rdata,
    .cache_off, .cmd_valid, .cmd_ready, .cmd_addr, .cmd_op);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [1:0] exp_op(input bit inv, input bit im);
    return !inv ? 2'b01 : (im ? 2'b11 : 2'b10);
  endfunction

  task automatic collect(input logic [39:0] first_ln, input int n, input logic [1:0] eop,
                         input string tag);
    int k = 0;
    int guard = 0;
    logic [31:0] d;
    while (k < n && guard < 2000) begin
      @(negedge clk); cmd_ready = ($urandom % 3) != 0; #1;
      if (cmd_valid) begin
        chk(cmd_addr == (first_ln + 40'(k)) * LB, {tag, " R3 addr"}, cmd_addr, (first_ln + 40'(k)) * LB);
        chk(cmd_op == eop, {tag, " R4 op"}, cmd_op, eop);
        if (cmd_ready) k++;
      end
      guard++;
    end
    chk(k == n, {tag, " R3 count"}, k, n);
    @(negedge clk); cmd_ready = 1'b0;
    rd(12'h903, d);
    chk(!cmd_valid && !d[8], {tag, " R8 busy clear"}, d[8], 0);
  endtask

  task automatic region(input logic [39:0] s, input logic [39:0] e, input bit inv,
                        input bit im, input string tag);
    logic [31:0] d;
    logic [39:0] sl, el;
    sl = s / LB; el = e / LB;
    wr(12'h903, {20'd0, 2'b00, inv, 2'b00, im, 6'd0});
    wr(12'h917, 32'(e[39:32])); wr(12'h916, e[31:0]);
    wr(12'h915, 32'(s[39:32])); wr(12'h914, s[31:0]);
    rd(12'h903, d);
    chk(d[8], {tag, " R8 busy after launch"}, d[8], 1);
    if (el >= sl) collect(sl, int'(el - sl + 1), exp_op(inv, im), tag);
    else begin
      chk(!cmd_valid, {tag, " R6 no cmd"}, cmd_valid, 0);
      @(negedge clk); #1; rd(12'h903, d);
      chk(!d[8] && !cmd_valid, {tag, " R6 busy one cycle"}, d[8], 0);
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed1));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(12'h903, d);
    chk(d == 0 && !cmd_valid && !cache_off, "R1 reset", d, 0);

    wr(12'h903, 32'hFFFF_FFFF); rd(12'h903, d);
    chk(d == 32'h0000_0E41, "R2 ctrl fields", d, 32'hE41);
    chk(cache_off, "R2 cache_off", cache_off, 1);
    wr(12'h903, 32'h0); rd(12'h903, d);
    chk(d == 0 && !cache_off, "R2 ctrl clear", d, 0);

    wr(12'h915, 32'h1A5); rd(12'h915, d);
    chk(d == 32'hA5, "R11 start high width", d, 32'hA5);
    wr(12'h917, 32'h3C); rd(12'h917, d);
    chk(d == 32'h3C, "R11 end high", d, 32'h3C);
    wr(12'h916, 32'h1234_5678); rd(12'h916, d);
    chk(d == 32'h1234_5678, "R11 end low", d, 32'h1234_5678);

    region(40'h00_0000_1000, 40'h00_0000_10C0, 1'b0, 1'b0, "R3 flush 4 lines");
    region(40'h00_0000_203F, 40'h00_0000_2041, 1'b1, 1'b0, "R5 low bits inv");
    region(40'h00_0000_3000, 40'h00_0000_3000, 1'b1, 1'b1, "R4 single finv");
    region(40'h00_0000_4080, 40'h00_0000_4000, 1'b0, 1'b0, "R6 reversed");
    region(40'h02_FFFF_FF80, 40'h03_0000_0040, 1'b1, 1'b1, "R11 high carry");

    wr(12'h903, 32'h0); wr(12'h904, 32'h1); rd(12'h903, d);
    chk(d[8], "R7 flush all busy", d[8], 1);
    collect(40'd0, 16, 2'b01, "R7 flush all");
    wr(12'h903, 32'h40); wr(12'h905, 32'h1);
    collect(40'd0, 16, 2'b11, "R7 inv all im1");
    wr(12'h903, 32'h0); wr(12'h905, 32'h1);
    collect(40'd0, 16, 2'b10, "R7 inv all im0");
    wr(12'h904, 32'h2); @(negedge clk); #1;
    chk(!cmd_valid, "R7 bit0 clear no launch", cmd_valid, 0);

    wr(12'h903, 32'h200); wr(12'h917, 0); wr(12'h916, 32'h5080); wr(12'h915, 0);
    wr(12'h914, 32'h5000);
    wr(12'h914, 32'h9000); wr(12'h915, 32'h7); wr(12'h904, 32'h1); wr(12'h903, 32'h040);
    rd(12'h914, d);
    chk(d == 32'h5000, "R10 start low kept", d, 32'h5000);
    rd(12'h915, d);
    chk(d == 0, "R10 start high kept", d, 0);
    chk(cmd_valid && cmd_addr == 40'h5000 && cmd_op == 2'b10, "R10 walk unchanged", cmd_addr, 40'h5000);
    collect(40'h5000 / LB, 3, 2'b10, "R10 walk");
    rd(12'h903, d);
    chk(d == 32'h40, "R10 ctrl write stored", d, 32'h40);

    for (int i = 0; i < 25; i++) begin
      logic [39:0] s, e;
      s = {8'($urandom % 4), $urandom};
      e = ((s / LB) + 40'($urandom % 7)) * LB + 40'($urandom % LB);
      region(s, e, 1'($urandom), 1'($urandom), "R3 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule